// File: doc/BRIEF.md
# Character LCD Row Scanner

This block refreshes a 16-character, single-line dot-matrix panel at 1/16 duty. The panel has 16 common lines and 40 segment lines. The character line is folded into two blocks of eight characters, and the blocks share the segment lines. Commons 0 to 7 scan glyph rows 0 to 7 of characters 0 to 7. Commons 8 to 15 scan glyph rows 0 to 7 of characters 8 to 15.

For each common row the scanner reads character codes from an internal display RAM. It looks up a 5-dot slice for each character, either from a small pattern RAM or from a computed ROM stub. It shifts the 40 resulting dots serially, one per clock, into a shift register. Once every dot of the row is in, it loads them into the segment latch and switches the one-hot common output to that row at the same edge.

The host writes character codes and pattern-RAM words through simple write ports. The host also supplies its address counter, which places a cursor or a blinking character. A display-enable input blanks the segments while scanning continues.

Top module: `lcd_row_scanner`

## Requirements
- R1: While reset is asserted, and until the first row is latched, `com` and `seg` are all zero. Reset also clears every display-RAM and pattern-RAM word to zero.
- R2: The first row (common 0) appears 40 clocks after reset is released. From then on, every 40 clocks `com` moves to the next common in ascending order (0 to 15, then back to 0), and it always has exactly one bit set.
- R3: Common r shows glyph row r mod 8 of characters 8·(r div 8) to 8·(r div 8)+7. Character k of that group sits on `seg[5k+4:5k]`, and `seg[5k+d]` carries dot d (d=0 is the leftmost dot), which is bit 4−d of the 5-bit slice.
- R4: A code of 0 to 3 takes its slice from pattern-RAM word `{code[1:0], glyph_row[2:0]}`, which is also the `pat_waddr` the host writes. Code 3 is the last pattern-RAM code.
- R5: A code of 4 or above takes its slice from the ROM stub, which equals `code[4:0]` XOR the glyph row.
- R6: `seg` changes only at the edge where `com` changes. It never shows a partially shifted row.
- R7: A host write to display RAM changes only rows shifted after the write. The row currently on the outputs stays as latched.
- R8: With `cursor_on` high, glyph row 7 of the character whose index equals `addr_ctr[3:0]` is forced to all five dots on. Other rows and other characters are unchanged.
- R9: `addr_ctr[6:4]` is ignored. A pattern-RAM address in the counter still places the cursor or blink at the character given by its low four bits.
- R10: The blink phase is off after reset and toggles every 16 frames (half of `BLINK_FRAMES`). A frame is 16 rows. During the on phase, with `blink_on` high, every dot of the selected character is inverted, and this inversion is applied after the cursor.
- R11: `disp_on` is sampled at each row boundary. When it is low, the latched segments are all zero while `com` keeps scanning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dd_we | input | 1 | Display-RAM write strobe |
| dd_waddr | input | 4 | Display-RAM character index |
| dd_wdata | input | 8 | Character code to store |
| pat_we | input | 1 | Pattern-RAM write strobe |
| pat_waddr | input | 5 | Pattern-RAM word: {glyph[1:0], row[2:0]} |
| pat_wdata | input | 5 | Glyph row slice, bit 4 = leftmost dot |
| addr_ctr | input | 7 | Host address counter, low 4 bits pick the character |
| disp_on | input | 1 | Display enable, sampled at row boundaries |
| cursor_on | input | 1 | Cursor underline enable |
| blink_on | input | 1 | Character blink enable |
| com | output | 16 | One-hot common drive |
| seg | output | 40 | Latched segment dots |

## Verification
The assertions check the following on every cycle:
- `com` is one-hot and rotates in order with a 40-clock period.
- `seg` moves only with `com`.
- `seg` is blank before the first row and after a row latched with the display off.

The glyph content needs the bench's scenarios and its behavioural model. This covers the dot ordering, the split between pattern RAM and ROM at code 3/4, the cursor row, the blink inversion over a 32-frame window, and the point at which a host write becomes visible.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
   // Source of a character's glyph slice
   typedef enum logic {
      SRC_PATTERN = 1'b0,
      SRC_ROM     = 1'b1
   } glyph_src_e;
endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
   parameter int DOTS         = 5,
   parameter int CPB          = 8,
   parameter int N_COM        = 16,
   parameter int BLINK_FRAMES = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   output logic [$clog2(DOTS)-1:0]  dot,
   output logic [$clog2(CPB)-1:0]   chr,
   output logic [$clog2(N_COM)-1:0] row,
   output logic                     row_done,
   output logic                     blink_ph
);
   localparam int DOT_W = $clog2(DOTS);
   localparam int CHR_W = $clog2(CPB);
   localparam int ROW_W = $clog2(N_COM);

   logic at_dot_end, at_chr_end, frame_done;

   assign at_dot_end = (dot == DOT_W'(DOTS - 1));
   assign at_chr_end = (chr == CHR_W'(CPB - 1));
   assign row_done   = at_dot_end && at_chr_end;
   assign frame_done = row_done && (row == ROW_W'(N_COM - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dot <= '0;
         chr <= '0;
         row <= '0;
      end else if (at_dot_end) begin
         dot <= '0;
         if (at_chr_end) begin
            chr <= '0;
            row <= (row == ROW_W'(N_COM - 1)) ? '0 : row + 1'b1;
         end else begin
            chr <= chr + 1'b1;
         end
      end else begin
         dot <= dot + 1'b1;
      end
   end

   generate
      if (BLINK_FRAMES >= 2) begin : g_blink
         localparam int HALF = BLINK_FRAMES / 2;
         localparam int FC_W = $clog2(HALF + 1);
         logic [FC_W-1:0] fcnt;
         logic            ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fcnt <= '0;
               ph   <= 1'b0;
            end else if (frame_done) begin
               if (fcnt == FC_W'(HALF - 1)) begin
                  fcnt <= '0;
                  ph   <= ~ph;
               end else begin
                  fcnt <= fcnt + 1'b1;
               end
            end
         end
         assign blink_ph = ph;
      end else begin : g_no_blink
         logic unused_frame;
         assign unused_frame = frame_done;
         assign blink_ph     = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/lcd_glyph_fetch.sv
module lcd_glyph_fetch
   import lcd_scan_pkg::*;
#(
   parameter int DOTS      = 5,
   parameter int GROWS     = 8,
   parameter int CHARS     = 16,
   parameter int CPB       = 8,
   parameter int N_COM     = 16,
   parameter int CG_GLYPHS = 4,
   parameter int CODE_W    = 8,
   parameter int AC_W      = 7
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 dd_we,
   input  logic [$clog2(CHARS)-1:0]             dd_waddr,
   input  logic [CODE_W-1:0]                    dd_wdata,
   input  logic                                 pat_we,
   input  logic [$clog2(CG_GLYPHS*GROWS)-1:0]   pat_waddr,
   input  logic [DOTS-1:0]                      pat_wdata,
   input  logic [$clog2(DOTS)-1:0]              dot,
   input  logic [$clog2(CPB)-1:0]               chr,
   input  logic [$clog2(N_COM)-1:0]             row,
   input  logic [AC_W-1:0]                      addr_ctr,
   input  logic                                 cursor_on,
   input  logic                                 blink_on,
   input  logic                                 blink_ph,
   output logic                                 dot_bit
);
   localparam int CHAR_AW = $clog2(CHARS);
   localparam int CG_N    = CG_GLYPHS * GROWS;
   localparam int CGI_W   = $clog2(CG_GLYPHS);
   localparam int ROW_W   = $clog2(N_COM);
   localparam int GROW_W  = $clog2(GROWS);
   localparam int DOT_W   = $clog2(DOTS);

   logic [CODE_W-1:0] dd_mem  [CHARS];
   logic [DOTS-1:0]   pat_mem [CG_N];

   // Host write port, independent of the scan read path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CHARS; i++) dd_mem[i] <= '0;
         for (int j = 0; j < CG_N; j++) pat_mem[j] <= '0;
      end else begin
         if (dd_we)  dd_mem[dd_waddr]   <= dd_wdata;
         if (pat_we) pat_mem[pat_waddr] <= pat_wdata;
      end
   end

   logic [GROW_W-1:0]  grow;
   logic [CHAR_AW-1:0] cidx;
   logic [CODE_W-1:0]  code;
   logic [DOTS-1:0]    pat_slice, rom_slice, shaped;
   glyph_src_e         src;
   logic               hit;
   logic [AC_W-CHAR_AW-1:0] unused_ac_hi;

   assign grow         = row[GROW_W-1:0];
   assign cidx         = {row[ROW_W-1:GROW_W], chr};
   assign code         = dd_mem[cidx];
   assign src          = (code < CODE_W'(CG_GLYPHS)) ? SRC_PATTERN : SRC_ROM;
   assign pat_slice    = pat_mem[{code[CGI_W-1:0], grow}];
   assign rom_slice    = code[DOTS-1:0] ^ DOTS'(grow);
   assign hit          = (cidx == addr_ctr[CHAR_AW-1:0]);
   assign unused_ac_hi = addr_ctr[AC_W-1:CHAR_AW];

   always_comb begin
      shaped = (src == SRC_PATTERN) ? pat_slice : rom_slice;
      if (cursor_on && hit && (grow == GROW_W'(GROWS - 1))) shaped = '1;
      if (blink_on && blink_ph && hit) shaped = ~shaped;
   end

   assign dot_bit = shaped[DOT_W'(DOTS - 1) - dot];
endmodule

// File: rtl/lcd_seg_shifter.sv
module lcd_seg_shifter #(
   parameter int SEG_W = 40,
   parameter int N_COM = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bit_in,
   input  logic                     row_done,
   input  logic [$clog2(N_COM)-1:0] row,
   input  logic                     disp_on,
   output logic [N_COM-1:0]         com,
   output logic [SEG_W-1:0]         seg
);
   localparam int ROW_W = $clog2(N_COM);

   logic [SEG_W-2:0] sr;
   logic [SEG_W-1:0] sr_next;
   logic [N_COM-1:0] row_hot;

   assign sr_next = {bit_in, sr};

   generate
      for (genvar g = 0; g < N_COM; g++) begin : g_com_dec
         assign row_hot[g] = (row == ROW_W'(g));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr  <= '0;
         seg <= '0;
         com <= '0;
      end else begin
         sr <= sr_next[SEG_W-1:1];
         if (row_done) begin
            seg <= disp_on ? sr_next : '0;
            com <= row_hot;
         end
      end
   end
endmodule

// File: rtl/lcd_row_scanner.sv
module lcd_row_scanner #(
   parameter int N_COM        = 16,
   parameter int N_BLOCK      = 2,
   parameter int CHARS        = 16,
   parameter int DOTS         = 5,
   parameter int GROWS        = 8,
   parameter int CG_GLYPHS    = 4,
   parameter int CODE_W       = 8,
   parameter int AC_W         = 7,
   parameter int BLINK_FRAMES = 32
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                dd_we,
   input  logic [$clog2(CHARS)-1:0]            dd_waddr,
   input  logic [CODE_W-1:0]                   dd_wdata,
   input  logic                                pat_we,
   input  logic [$clog2(CG_GLYPHS*GROWS)-1:0]  pat_waddr,
   input  logic [DOTS-1:0]                     pat_wdata,
   input  logic [AC_W-1:0]                     addr_ctr,
   input  logic                                disp_on,
   input  logic                                cursor_on,
   input  logic                                blink_on,
   output logic [N_COM-1:0]                    com,
   output logic [(CHARS/N_BLOCK)*DOTS-1:0]     seg
);
   localparam int CPB   = CHARS / N_BLOCK;
   localparam int SEG_W = CPB * DOTS;
   localparam int DOT_W = $clog2(DOTS);
   localparam int CHR_W = $clog2(CPB);
   localparam int ROW_W = $clog2(N_COM);

   generate
      if (N_COM != N_BLOCK * GROWS) begin : g_bad_com
         $error("common count must equal blocks times glyph rows");
      end
      if (CHARS != N_BLOCK * CPB) begin : g_bad_chars
         $error("characters must split evenly over blocks");
      end
      if ((N_BLOCK < 2) || ((N_BLOCK & (N_BLOCK - 1)) != 0)) begin : g_bad_blk
         $error("block count must be a power of two, at least 2");
      end
      if (((GROWS & (GROWS - 1)) != 0) || ((CPB & (CPB - 1)) != 0)) begin : g_bad_pow
         $error("glyph rows and characters per block must be powers of two");
      end
      if ((CG_GLYPHS < 2) || ((CG_GLYPHS & (CG_GLYPHS - 1)) != 0)) begin : g_bad_cg
         $error("pattern glyph count must be a power of two, at least 2");
      end
      if ((DOTS < 2) || (DOTS > CODE_W) || (AC_W <= $clog2(CHARS))) begin : g_bad_w
         $error("dot count or counter width out of range");
      end
   endgenerate

   logic [DOT_W-1:0] dot;
   logic [CHR_W-1:0] chr;
   logic [ROW_W-1:0] row;
   logic             row_done, blink_ph, dot_bit;

   lcd_scan_timer #(
      .DOTS(DOTS), .CPB(CPB), .N_COM(N_COM), .BLINK_FRAMES(BLINK_FRAMES)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .dot(dot), .chr(chr), .row(row),
      .row_done(row_done), .blink_ph(blink_ph)
   );

   lcd_glyph_fetch #(
      .DOTS(DOTS), .GROWS(GROWS), .CHARS(CHARS), .CPB(CPB), .N_COM(N_COM),
      .CG_GLYPHS(CG_GLYPHS), .CODE_W(CODE_W), .AC_W(AC_W)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .dd_we(dd_we), .dd_waddr(dd_waddr), .dd_wdata(dd_wdata),
      .pat_we(pat_we), .pat_waddr(pat_waddr), .pat_wdata(pat_wdata),
      .dot(dot), .chr(chr), .row(row), .addr_ctr(addr_ctr),
      .cursor_on(cursor_on), .blink_on(blink_on), .blink_ph(blink_ph),
      .dot_bit(dot_bit)
   );

   lcd_seg_shifter #(
      .SEG_W(SEG_W), .N_COM(N_COM)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .bit_in(dot_bit), .row_done(row_done),
      .row(row), .disp_on(disp_on), .com(com), .seg(seg)
   );
endmodule

// File: rtl/lcd_row_scanner_checker.sv
module lcd_row_scanner_checker #(
   parameter int N_COM = 16,
   parameter int SEG_W = 40
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_COM-1:0] com,
   input logic [SEG_W-1:0] seg,
   input logic             disp_on
);
   localparam int GAP_W = $clog2(SEG_W + 2) + 1;

   logic [N_COM-1:0] com_d;
   logic [GAP_W-1:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         com_d <= '0;
         gap   <= '0;
      end else begin
         com_d <= com;
         if (com != com_d)  gap <= GAP_W'(1);
         else if (gap != '1) gap <= gap + 1'b1;
      end
   end

   // R1: nothing on the segments before a row is on the commons
   a_r1_blank_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (com == '0) |-> (seg == '0));

   // R2: at most one common active
   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(com));

   // R2: commons advance in ascending order with wrap
   a_r2_rotate: assert property (@(posedge clk) disable iff (!rst_n)
      ((com != com_d) && (com_d != '0)) |-> (com == {com_d[N_COM-2:0], com_d[N_COM-1]}));

   // R2: one row lasts exactly one full shift
   a_r2_period: assert property (@(posedge clk) disable iff (!rst_n)
      ((com != com_d) && (com_d != '0)) |-> (gap == GAP_W'(SEG_W)));

   // R6: segments move only together with the commons
   a_r6_latch_only: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(com) |-> $stable(seg));

   // R11: a row latched with the display off is blank
   a_r11_blank_off: assert property (@(posedge clk) disable iff (!rst_n)
      ((com != com_d) && !$past(disp_on)) |-> (seg == '0));
endmodule

bind lcd_row_scanner lcd_row_scanner_checker #(
   .N_COM(N_COM), .SEG_W(SEG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .com(com), .seg(seg), .disp_on(disp_on)
);

// File: tb/lcd_row_scanner_test.sv
module lcd_row_scanner_test;
   localparam int BLINK = 32;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        dd_we, pat_we, disp_on, cursor_on, blink_on;
   logic [3:0]  dd_waddr;
   logic [7:0]  dd_wdata;
   logic [4:0]  pat_waddr, pat_wdata;
   logic [6:0]  addr_ctr;
   logic [15:0] com;
   logic [39:0] seg;

   always #5 clk = ~clk;

   lcd_row_scanner uut (
      .clk(clk), .rst_n(rst_n), .dd_we(dd_we), .dd_waddr(dd_waddr), .dd_wdata(dd_wdata),
      .pat_we(pat_we), .pat_waddr(pat_waddr), .pat_wdata(pat_wdata), .addr_ctr(addr_ctr),
      .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on), .com(com), .seg(seg)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Behavioural reference model: one dot per clock, row by row
   logic [7:0]  m_dd [16];
   logic [4:0]  m_pat [32];
   int          m_dot, m_chr, m_row, m_fc, mb_g, mb_ci, mb_code, mb_sl;
   bit          m_ph;
   logic [39:0] m_acc, exp_seg;
   logic [15:0] exp_com;

   always @(posedge clk) begin
      if (rst_n !== 1'b1) begin
         m_dot = 0; m_chr = 0; m_row = 0; m_fc = 0; m_ph = 0;
         m_acc = '0; exp_seg = '0; exp_com = '0;
         for (int i = 0; i < 16; i++) m_dd[i] = '0;
         for (int i = 0; i < 32; i++) m_pat[i] = '0;
      end else begin
         mb_g    = m_row % 8;
         mb_ci   = (m_row / 8) * 8 + m_chr;
         mb_code = m_dd[mb_ci];
         if (mb_code < 4) mb_sl = m_pat[mb_code * 8 + mb_g];
         else             mb_sl = (mb_code ^ mb_g) & 31;
         if (cursor_on && mb_ci == (addr_ctr & 15) && mb_g == 7) mb_sl = 31;
         if (blink_on && m_ph && mb_ci == (addr_ctr & 15)) mb_sl = mb_sl ^ 31;
         m_acc[m_chr * 5 + m_dot] = (mb_sl >> (4 - m_dot)) & 1;
         if (m_dot == 4 && m_chr == 7) begin
            exp_seg = disp_on ? m_acc : '0;
            exp_com = 16'b1 << m_row;
            if (m_row == 15) begin
               m_fc++;
               if (m_fc == BLINK / 2) begin m_fc = 0; m_ph = ~m_ph; end
            end
            m_row = (m_row + 1) % 16;
            m_chr = 0; m_dot = 0;
         end else if (m_dot == 4) begin
            m_dot = 0; m_chr++;
         end else begin
            m_dot++;
         end
         if (dd_we)  m_dd[dd_waddr]   = dd_wdata;
         if (pat_we) m_pat[pat_waddr] = pat_wdata;
      end
   end

   // Compare against the model on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         check("R2 com vs model", com, exp_com);
         check("R3 seg vs model", seg, exp_seg);
      end
   end

   task automatic wr_dd(input int a, input int d);
      @(negedge clk);
      dd_we = 1; dd_waddr = 4'(a); dd_wdata = 8'(d);
      @(negedge clk);
      dd_we = 0;
   endtask

   task automatic wr_pat(input int a, input int d);
      @(negedge clk);
      pat_we = 1; pat_waddr = 5'(a); pat_wdata = 5'(d);
      @(negedge clk);
      pat_we = 0;
   endtask

   task automatic wait_row(input int r);
      logic [15:0] tgt;
      tgt = 16'b1 << r;
      while (com === tgt) @(negedge clk);
      while (com !== tgt) @(negedge clk);
   endtask

   task automatic summary();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired before all R1..R11 scenarios ended");
      summary();
      $finish;
   end

   initial begin
      logic [39:0] held;
      int on_cnt, off_cnt;
      rst_n = 0; dd_we = 0; pat_we = 0; dd_waddr = 0; dd_wdata = 0;
      pat_waddr = 0; pat_wdata = 0; addr_ctr = 0;
      disp_on = 1; cursor_on = 0; blink_on = 0;
      repeat (3) @(negedge clk);
      check("R1 com in reset", com, 16'h0);
      check("R1 seg in reset", seg, 40'h0);
      rst_n = 1;
      repeat (39) @(negedge clk);
      check("R1 com before first row", com, 16'h0);
      @(negedge clk);
      check("R2 first row after 40 clocks", com, 16'h0001);

      wr_pat({2'd1, 3'd2}, 5'b11000);
      wr_pat({2'd3, 3'd0}, 5'b10000);
      wr_dd(0, 1);
      wr_dd(2, 3);
      wr_dd(3, 4);
      wr_dd(9, 8'h41);
      wait_row(15);

      wait_row(0);
      check("R4 code 3 pattern glyph", seg[14:10], 5'b00001);
      check("R4 code 4 goes to rom", seg[19:15], 5'b00100);
      wait_row(2);
      check("R3 dot order of pattern row", seg[4:0], 5'b00011);
      wait_row(10);
      check("R5 rom stub second block", seg[9:5], 5'b11000);
      check("R3 block1 char8 blank", seg[4:0], 5'b00000);

      // host write while row 10 is on the outputs
      held = seg;
      wr_dd(9, 8'h55);
      repeat (20) @(negedge clk);
      check("R6 R7 displayed row untouched", seg, held);
      wait_row(15);
      wait_row(10);
      check("R7 new code visible next frame", seg[9:5], 5'b11101);

      cursor_on = 1; addr_ctr = 7'h03;
      wait_row(15);
      wait_row(6);
      check("R8 cursor leaves row 6", seg[19:15], 5'b01000);
      wait_row(7);
      check("R8 cursor row forced on", seg[19:15], 5'b11111);

      addr_ctr = 7'h4B;
      wait_row(0);
      wait_row(7);
      check("R9 old cursor char clear", seg[19:15], 5'b11000);
      wait_row(15);
      check("R9 high counter bits ignored", seg[19:15], 5'b11111);
      cursor_on = 0;

      blink_on = 1; addr_ctr = 7'h02;
      wait_row(1);
      on_cnt = 0; off_cnt = 0;
      for (int f = 0; f < BLINK; f++) begin
         wait_row(0);
         if (seg[14:10] === 5'b11110) on_cnt++;
         else if (seg[14:10] === 5'b00001) off_cnt++;
      end
      check("R10 inverted frames in window", on_cnt, 16);
      check("R10 normal frames in window", off_cnt, 16);
      blink_on = 0;

      disp_on = 0;
      wait_row(3);
      check("R11 blank while off", seg, 40'h0);
      check("R11 scan continues", com, 16'h0008);
      wait_row(4);
      check("R11 still blank", seg, 40'h0);
      disp_on = 1;
      wait_row(5);
      check("R11 restored after enable", seg[19:15], 5'b10000);

      @(negedge clk);
      summary();
      $finish;
   end
endmodule